// File: doc/BRIEF.md
# Run-time depth-selectable UART FIFO pair

This block holds the transmit and receive byte queues of a serial port. Their usable depth is chosen while the port runs. Three small control registers and one configuration pin set the depth. A priority decode of those inputs picks one of five compatibility modes:

- a single-entry holding register;
- a 16-entry queue;
- one of three 128-entry variants.

One control bit is write-protected by a guard bit in another register. Software must open the guard before that bit can change.

Both queues always sit on the same 128-entry storage, and their pointers wrap at 128. Only the occupancy limit follows the mode. When the limit shrinks, or when the queue-enable bit changes, both queues are emptied. No queue can then hold more entries than its new limit allows. A receive push that finds the queue full is lost, and a sticky overrun flag records the loss.

The register port is a one-cycle write strobe with a 2-bit address. Reads are combinational.

| Address | Register | Bits that matter |
|---|---|---|
| 0 | queue control | bit 0 is queue enable; bit 5 is deep select, guarded |
| 1 | line control | bit 7 is the guard |
| 2 | feature control | bit 4 is enhanced mode |

Top module: `fifo_mode_ctrl`

## Requirements
- R1: After reset the mode output is 0 (byte). Both queues are empty with level 0, and addresses 0, 1 and 2 read back 0.
- R2: While queue enable (address 0, bit 0) is 0, the mode is 0 and the depth is 1, whatever deep select, enhanced mode (address 2, bit 4) or the pin hold.
- R3: With enable 1, enhanced 0, deep select 0 and the pin 0, the mode is 1 and each queue accepts 16 entries.
- R4: With enable 1, enhanced 0, deep select 0 and the pin 1, the mode is 2 and each queue accepts 128 entries.
- R5: With enable 1, enhanced 0 and deep select 1, the mode is 3 and the depth is 128, for either pin value.
- R6: With enable 1 and enhanced 1, the mode is 4 and the depth is 128, whatever deep select and the pin hold.
- R7: A write to address 0 changes deep select (bit 5) only while line control bit 7 is 1. Otherwise deep select keeps its old value and reads back unchanged at address 0, bit 5.
- R8: A mode or enable change empties both queues in the cycle it takes effect if the depth shrinks or the enable bit changes. A change that keeps or grows the depth with enable unchanged keeps the queued data.
- R9: Full is 1 when the level equals the current depth. A push while full is dropped, and neither the level nor the stored data changes.
- R10: A receive push while full sets the overrun output. Overrun stays set until the next emptying of the queues by R8.
- R11: Each queue returns entries in push order. The oldest entry is shown on its read-data output before the pop. A pop while empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register address |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register read data at reg_addr |
| depth_pin | input | 1 | configuration pin selecting 128 entries in place of 16 |
| tx_push | input | 1 | transmit queue push |
| tx_wdata | input | 8 | transmit push data |
| tx_pop | input | 1 | transmit queue pop |
| tx_rdata | output | 8 | oldest transmit entry |
| tx_full | output | 1 | transmit queue at depth |
| tx_empty | output | 1 | transmit queue empty |
| tx_level | output | 8 | transmit occupancy |
| rx_push | input | 1 | receive queue push |
| rx_wdata | input | 8 | receive push data |
| rx_pop | input | 1 | receive queue pop |
| rx_rdata | output | 8 | oldest receive entry |
| rx_full | output | 1 | receive queue at depth |
| rx_empty | output | 1 | receive queue empty |
| rx_level | output | 8 | receive occupancy |
| rx_overrun | output | 1 | sticky receive overrun |
| mode | output | 3 | active mode code |

## Verification
The hardest case to reach is a mode change on a queue that already holds data. The bench must tell a shrink, which empties the queues, from a grow or an equal-depth change, which keeps the data. To reach it, the bench fills the transmit queue in the extended mode and then drops the pin. It then refills the queue in the standard mode, raises the pin, and finally switches to the enhanced mode. It checks the level after each change. Deep select can only be set through the guard, so every table vector opens the guard, writes the control bits, and closes the guard again. Each vector then streams 130 pushes to show the exact depth limit.

// File: rtl/fifo_mode_pkg.sv
package fifo_mode_pkg;

    typedef enum logic [2:0] {
        MODE_BYTE    = 3'd0,
        MODE_STD16   = 3'd1,
        MODE_EXT128  = 3'd2,
        MODE_DEEP128 = 3'd3,
        MODE_ENH128  = 3'd4
    } fifo_mode_e;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_QCTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LCTL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FCTL = 2'd2;

    localparam int unsigned BIT_ENABLE = 0;
    localparam int unsigned BIT_DEEP   = 5;
    localparam int unsigned BIT_GUARD  = 7;
    localparam int unsigned BIT_ENH    = 4;

    function automatic fifo_mode_e decode_mode(input logic en, input logic deep,
                                               input logic enh, input logic pin);
        if (!en)       return MODE_BYTE;
        else if (enh)  return MODE_ENH128;
        else if (deep) return MODE_DEEP128;
        else if (pin)  return MODE_EXT128;
        else           return MODE_STD16;
    endfunction

endpackage

// File: rtl/fifo_mode_regs.sv
module fifo_mode_regs
    import fifo_mode_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned SHALLOW_DEPTH = 16,
    parameter int unsigned DEEP_DEPTH    = 128,
    localparam int unsigned CNT_W        = $clog2(DEEP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pin,
    output fifo_mode_e        mode,
    output logic [CNT_W-1:0]  limit,
    output logic              flush
);

    typedef struct packed {
        logic              en;
        logic              deep;
        logic [DATA_W-1:0] line;
        logic [DATA_W-1:0] feat;
        fifo_mode_e        mode;
    } regs_t;

    regs_t s_d, s_q;

    function automatic logic [CNT_W-1:0] depth_of(input fifo_mode_e m);
        case (m)
            MODE_BYTE:  return CNT_W'(1);
            MODE_STD16: return CNT_W'(SHALLOW_DEPTH);
            default:    return CNT_W'(DEEP_DEPTH);
        endcase
    endfunction

    always_comb begin
        s_d = s_q;
        if (we) begin
            case (addr)
                ADDR_QCTL: begin
                    s_d.en = wdata[BIT_ENABLE];
                    if (s_q.line[BIT_GUARD]) s_d.deep = wdata[BIT_DEEP];
                end
                ADDR_LCTL: s_d.line = wdata;
                ADDR_FCTL: s_d.feat = wdata;
                default: ;
            endcase
        end
        s_d.mode = decode_mode(s_d.en, s_d.deep, s_d.feat[BIT_ENH], pin);
        flush    = (depth_of(s_d.mode) < depth_of(s_q.mode)) || (s_d.en != s_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_QCTL: begin
                rdata[BIT_ENABLE] = s_q.en;
                rdata[BIT_DEEP]   = s_q.deep;
            end
            ADDR_LCTL: rdata = s_q.line;
            ADDR_FCTL: rdata = s_q.feat;
            default:   rdata = '0;
        endcase
    end

    assign mode  = s_q.mode;
    assign limit = depth_of(s_q.mode);

    assert_guard_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_QCTL && !s_q.line[BIT_GUARD]) |=> (s_q.deep == $past(s_q.deep)));

    assert_enh_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_FCTL && wdata[BIT_ENH] && s_q.en &&
         !(we && addr == ADDR_QCTL)) |=> (mode == MODE_ENH128));

endmodule

// File: rtl/fifo_mode_buf.sv
module fifo_mode_buf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CNT_W-1:0]  limit,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  level
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } buf_t;

    buf_t s_d, s_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (s_q.cnt == limit);
    assign empty = (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = wdata;
                s_d.wr          = bump(s_q.wr);
            end
            if (do_pop) s_d.rd = bump(s_q.rd);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[s_q.rd];
    assign level = s_q.cnt;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= limit);

    assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    assert_pop_empty_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/fifo_mode_ctrl.sv
module fifo_mode_ctrl
    import fifo_mode_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned SHALLOW_DEPTH = 16,
    parameter int unsigned DEEP_DEPTH    = 128
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_we,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    input  logic                               depth_pin,
    input  logic                               tx_push,
    input  logic [DATA_W-1:0]                  tx_wdata,
    input  logic                               tx_pop,
    output logic [DATA_W-1:0]                  tx_rdata,
    output logic                               tx_full,
    output logic                               tx_empty,
    output logic [$clog2(DEEP_DEPTH+1)-1:0]    tx_level,
    input  logic                               rx_push,
    input  logic [DATA_W-1:0]                  rx_wdata,
    input  logic                               rx_pop,
    output logic [DATA_W-1:0]                  rx_rdata,
    output logic                               rx_full,
    output logic                               rx_empty,
    output logic [$clog2(DEEP_DEPTH+1)-1:0]    rx_level,
    output logic                               rx_overrun,
    output logic [2:0]                         mode
);

    localparam int unsigned CNT_W = $clog2(DEEP_DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t       s_d, s_q;
    fifo_mode_e mode_w;
    logic [CNT_W-1:0] limit_w;
    logic       flush_w;

    fifo_mode_regs #(
        .DATA_W        (DATA_W),
        .SHALLOW_DEPTH (SHALLOW_DEPTH),
        .DEEP_DEPTH    (DEEP_DEPTH)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .pin   (depth_pin),
        .mode  (mode_w),
        .limit (limit_w),
        .flush (flush_w)
    );

    fifo_mode_buf #(.DATA_W(DATA_W), .DEPTH(DEEP_DEPTH)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_w),
        .limit (limit_w),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    fifo_mode_buf #(.DATA_W(DATA_W), .DEPTH(DEEP_DEPTH)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_w),
        .limit (limit_w),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    always_comb begin
        s_d = s_q;
        if (flush_w)                s_d.ovr = 1'b0;
        else if (rx_push && rx_full) s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_overrun = s_q.ovr;
    assign mode       = mode_w;

    assert_byte_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_BYTE) |-> (tx_level <= CNT_W'(1) && rx_level <= CNT_W'(1)));

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !flush_w) |=> rx_overrun);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !flush_w) |=> rx_overrun);

endmodule

// File: tb/fifo_mode_ctrl_bench.sv
module fifo_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       depth_pin = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic       tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
    logic [7:0] tx_level, rx_level;
    logic [2:0] mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fifo_mode_ctrl u_fifo_mode_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .depth_pin(depth_pin),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level),
        .rx_overrun(rx_overrun), .mode(mode)
    );

    // {enable, deep, enhanced, pin, mode[2:0], depth[7:0]}
    localparam logic [14:0] VECS [9] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd1},
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'd1},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'd16},
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 8'd128},
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 8'd128},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 8'd128},
        {1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 8'd128},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 8'd128},
        {1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 8'd128}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; depth_pin = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tx_stream(input int n, input int base);
        @(negedge clk);
        tx_push = 1'b1;
        for (int i = 0; i < n; i++) begin
            tx_wdata = 8'(base + i);
            @(negedge clk);
        end
        tx_push = 1'b0;
    endtask

    task automatic rx_stream(input int n);
        @(negedge clk);
        rx_push = 1'b1;
        for (int i = 0; i < n; i++) begin
            rx_wdata = 8'(i);
            @(negedge clk);
        end
        rx_push = 1'b0;
    endtask

    task automatic tx_pop_n(input int n);
        @(negedge clk);
        tx_pop = 1'b1;
        repeat (n) @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rx_pop_n(input int n);
        @(negedge clk);
        rx_pop = 1'b1;
        repeat (n) @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        do_reset();
        #1;
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_level", rx_level, 0);
        rd(2'd0, r); check("R1 qctl", r, 0);
        rd(2'd1, r); check("R1 lctl", r, 0);
        rd(2'd2, r); check("R1 fctl", r, 0);

        // Decode table: R2 R3 R4 R5 R6
        for (int v = 0; v < 9; v++) begin
            logic [14:0] e;
            e = VECS[v];
            do_reset();
            @(negedge clk); depth_pin = e[11];
            wr(2'd1, 8'h80);
            wr(2'd0, {2'b00, e[13], 4'b0000, e[14]});
            wr(2'd1, 8'h00);
            wr(2'd2, {3'b000, e[12], 4'b0000});
            #1;
            check($sformatf("R2-R6 vec%0d mode (R2 R3 R4 R5 R6)", v), mode, int'(e[10:8]));
            tx_stream(130, 0);
            #1;
            check($sformatf("R9 vec%0d depth", v), tx_level, int'(e[7:0]));
            check($sformatf("R9 vec%0d full", v), tx_full, 1);
            check($sformatf("R11 vec%0d head", v), tx_rdata, 0);
        end

        // R7 guard on deep select
        do_reset();
        wr(2'd0, 8'h21);
        #1 rd(2'd0, r); check("R7 closed guard", r, 8'h01);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h21);
        #1 rd(2'd0, r); check("R7 open guard", r, 8'h21);
        check("R7 mode deep", mode, 3);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        #1 rd(2'd0, r); check("R7 kept deep", r, 8'h21);

        // R11 ordering and pop on empty
        do_reset();
        wr(2'd0, 8'h01);
        tx_stream(3, 8'hA0);
        #1 check("R11 head A0", tx_rdata, 8'hA0);
        tx_pop_n(1); #1 check("R11 head A1", tx_rdata, 8'hA1);
        tx_pop_n(1); #1 check("R11 head A2", tx_rdata, 8'hA2);
        tx_pop_n(1); #1 check("R11 empty", tx_empty, 1);
        tx_pop_n(2); #1 check("R11 pop on empty", tx_level, 0);
        tx_stream(1, 8'h55);
        #1 check("R11 after empty pop", tx_rdata, 8'h55);

        // R9 R10 full drop and overrun
        do_reset();
        wr(2'd0, 8'h01);
        #1 check("R10 overrun clear", rx_overrun, 0);
        rx_stream(17);
        #1 check("R9 rx level", rx_level, 16);
        check("R10 overrun set", rx_overrun, 1);
        rx_pop_n(15);
        #1 check("R9 dropped data", rx_rdata, 15);
        check("R9 rx level after pops", rx_level, 1);
        check("R10 overrun sticky", rx_overrun, 1);
        wr(2'd0, 8'h00);
        #1 check("R10 overrun cleared by flush", rx_overrun, 0);
        check("R8 enable change flush", rx_level, 0);
        check("R2 mode byte", mode, 0);

        // R8 shrink versus grow
        do_reset();
        wr(2'd0, 8'h01);
        @(negedge clk); depth_pin = 1'b1;
        @(negedge clk); #1 check("R4 mode ext", mode, 2);
        tx_stream(20, 0);
        #1 check("R8 filled", tx_level, 20);
        @(negedge clk); depth_pin = 1'b0;
        @(negedge clk); #1 check("R8 shrink flush", tx_level, 0);
        check("R3 mode std", mode, 1);
        tx_stream(5, 8'h30);
        @(negedge clk); depth_pin = 1'b1;
        @(negedge clk); #1 check("R8 grow keeps", tx_level, 5);
        wr(2'd2, 8'h10);
        #1 check("R6 mode enh", mode, 4);
        check("R8 equal keeps", tx_level, 5);
        check("R8 data intact", tx_rdata, 8'h30);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule